// File: doc/BRIEF.md
# Tap-Select Interval Timer

A synchronous interval timer built on a 16-bit binary counter. Each cycle in which the count-enable tick is high, the counter advances by one. Two select inputs pick one of four counter stages to drive a single timer output. A polarity input inverts that output. A mode input chooses between two behaviours. In the first, the output is a free-running square wave. In the second, the output is a one-shot flag that goes high once half of the selected period has passed since the last master reset, and then stays high.

Counting is gated by an internal arm flag. When auto reset is enabled during the power-on reset, the emulated power-on pulse arms the timer, so counting starts by itself. When auto reset is disabled, the timer stays idle until a master reset pulse has been raised and then released. The master reset clears the counter and holds it at zero while high.

Top module: `tap_timer`

## Requirements
- R1: While armed, with master reset low and the timer not latched, the counter advances by exactly one on each clock edge at which tick_i is high.
- R2: sel_i = {B,A} picks the output stage: 2'b00 gives stage 13, 2'b01 gives stage 10, 2'b10 gives stage 8, 2'b11 gives stage 16. Stage N is counter bit N-1.
- R3: In continuous mode (oneshot_i = 0), the output equals the selected counter bit. With tick_i held high it toggles every 2^(N-1) ticks, so its period is 2^N ticks.
- R4: With inv_i = 1, the output is the logical inverse of what it would be with inv_i = 0. This includes the reset state.
- R5: In one-shot mode (oneshot_i = 1) with tick_i held high, the true-polarity output goes high right after the (2^(N-1)+1)-th clock edge at which master reset is sampled low. The first such edge arms the timer, and the counter then freezes.
- R6: Once latched in one-shot mode, the output holds high until master reset is asserted, which brings it low after one edge. Returning oneshot_i to 0 releases the latch: the output then follows the counter bit again and counting resumes.
- R7: With auto_en_i = 1 during the power-on reset (rst_ni low), the timer arms itself at the first edge after rst_ni is released, with no master reset needed.
- R8: With auto_en_i = 0, the output and counter stay idle after power-on until a master reset pulse has been asserted and released. The reset-state output is 0 for inv_i = 0.
- R9: While mrst_i is high, the counter is held at zero and the true-polarity output stays low, even with tick_i high.
- R10: Edges at which tick_i is low do not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | Count enable, one pulse per timebase tick |
| mrst_i | input | 1 | Master reset, active high; its release arms the timer |
| auto_en_i | input | 1 | Lets the power-on reset arm the timer |
| sel_i | input | 2 | Stage select {B,A} |
| inv_i | input | 1 | Output polarity, 1 = inverted |
| oneshot_i | input | 1 | 1 = one-shot latch mode, 0 = continuous square wave |
| tmr_o | output | 1 | Timer output |

## Verification
The bench measures the exact edge count from master-reset release to the output rising for all four stage selects. An off-by-one in the arming edge or a wrong select decode therefore shows up as a latency error. After the one-shot latches, the bench waits hundreds of extra cycles. A counter that keeps running would drop the output when the stage bit wraps. The bench then flips the mode back to continuous and checks the exact fall time, which a latch that fails to release or a counter that fails to resume would get wrong. A timer left idle with auto reset disabled is checked to stay low, and so is a timer held in master reset with ticks present. Either fault would let the output rise after 129 edges.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
  localparam int CNT_W_DEF = 16;
  typedef enum logic [1:0] {
    SEL_S13 = 2'b00,
    SEL_S10 = 2'b01,
    SEL_S8  = 2'b10,
    SEL_S16 = 2'b11
  } tap_sel_e;
endpackage

// File: rtl/tt_arm.sv
module tt_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic mrst_i,
  output logic armed_o
);
  logic por_q, mrst_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q   <= 1'b1;
      mrst_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      por_q  <= 1'b0;
      mrst_q <= mrst_i;
      if (mrst_i)                                armed_q <= 1'b0;
      else if ((por_q && auto_en_i) || mrst_q)   armed_q <= 1'b1;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tt_tap.sv
module tt_tap
  import tap_timer_pkg::*;
#(
  parameter int W      = 16,
  parameter int STG_S8  = 8,
  parameter int STG_S10 = 10,
  parameter int STG_S13 = 13,
  parameter int STG_S16 = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic [1:0]   sel_i,
  output logic         bit_o
);
  localparam int IW = $clog2(W);
  logic [IW-1:0] idx;

  always_comb begin
    unique case (tap_sel_e'(sel_i))
      SEL_S13: idx = IW'(STG_S13 - 1);
      SEL_S10: idx = IW'(STG_S10 - 1);
      SEL_S8:  idx = IW'(STG_S8 - 1);
      default: idx = IW'(STG_S16 - 1);
    endcase
  end

  assign bit_o = cnt_i[idx];
endmodule

// File: rtl/tt_out.sv
module tt_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic oneshot_i,
  input  logic inv_i,
  input  logic bit_i,
  output logic hold_o,
  output logic tmr_o
);
  logic done_q, hit;

  // latch keeps the flag high even if the tap moves to a clear bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   done_q <= 1'b0;
    else if (clr_i || !oneshot_i)  done_q <= 1'b0;
    else if (bit_i)                done_q <= 1'b1;
  end

  assign hit    = oneshot_i & (bit_i | done_q);
  assign hold_o = hit;
  assign tmr_o  = inv_i ^ (oneshot_i ? hit : bit_i);
endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tap_timer_pkg::*;
#(
  parameter int CNT_W   = CNT_W_DEF,
  parameter int STG_S8  = 8,
  parameter int STG_S10 = 10,
  parameter int STG_S13 = 13,
  parameter int STG_S16 = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       mrst_i,
  input  logic       auto_en_i,
  input  logic [1:0] sel_i,
  input  logic       inv_i,
  input  logic       oneshot_i,
  output logic       tmr_o
);
  logic             armed, hold, tap_bit, cnt_en;
  logic [CNT_W-1:0] cnt_q;

  tt_arm u_arm (
    .clk_i, .rst_ni, .auto_en_i, .mrst_i,
    .armed_o(armed)
  );

  assign cnt_en = armed & tick_i & ~hold & ~mrst_i;

  tt_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i(mrst_i),
    .en_i (cnt_en),
    .cnt_o(cnt_q)
  );

  tt_tap #(
    .W(CNT_W), .STG_S8(STG_S8), .STG_S10(STG_S10),
    .STG_S13(STG_S13), .STG_S16(STG_S16)
  ) u_tap (
    .cnt_i(cnt_q), .sel_i, .bit_o(tap_bit)
  );

  tt_out u_out (
    .clk_i, .rst_ni,
    .clr_i    (mrst_i),
    .oneshot_i,
    .inv_i,
    .bit_i    (tap_bit),
    .hold_o   (hold),
    .tmr_o
  );
endmodule

// File: rtl/tap_timer_chk.sv
module tap_timer_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         mrst_i,
  input logic         oneshot_i,
  input logic         armed_i,
  input logic         hold_i,
  input logic [W-1:0] cnt_i
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i && tick_i && !mrst_i && !oneshot_i |=> cnt_i == $past(cnt_i) + {{(W-1){1'b0}}, 1'b1}); // R1

  AST_MRST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> cnt_i == '0); // R9

  AST_IDLE_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i && !mrst_i |=> $stable(cnt_i)); // R8

  AST_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !mrst_i |=> $stable(cnt_i)); // R10

  AST_LATCH_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && oneshot_i && !mrst_i |=> $stable(cnt_i)); // R5

  AST_ARM_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mrst_i) |=> armed_i); // R6
endmodule

bind tap_timer tap_timer_chk #(.W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .mrst_i   (mrst_i),
  .oneshot_i(oneshot_i),
  .armed_i  (armed),
  .hold_i   (hold),
  .cnt_i    (cnt_q)
);

// File: tb/sim_tap_timer.sv
`timescale 1ns/1ps
module sim_tap_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       mrst_i = 1'b0;
  logic       auto_en_i = 1'b0;
  logic [1:0] sel_i = 2'b10;
  logic       inv_i = 1'b0;
  logic       oneshot_i = 1'b0;
  logic       tmr_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  tap_timer u0 (
    .clk_i, .rst_ni, .tick_i, .mrst_i, .auto_en_i,
    .sel_i, .inv_i, .oneshot_i, .tmr_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts edges until tmr_o == val; returns max+1 on timeout
  task automatic wait_level(input logic val, input int max, output int n);
    n = 0;
    while (n <= max) begin
      @(posedge clk_i); #1;
      n++;
      if (tmr_o === val) return;
    end
  endtask

  task automatic pulse_mrst();
    @(negedge clk_i) mrst_i = 1'b1;
    repeat (2) @(negedge clk_i);
    mrst_i = 1'b0;
  endtask

  task automatic power_on(input logic auto_en);
    @(negedge clk_i);
    rst_ni = 1'b0; auto_en_i = auto_en;
    #1;
  endtask

  task automatic t_reset_state();
    power_on(1'b0);
    inv_i = 1'b0; #0.5;
    check(tmr_o === 1'b0, "R8 reset output", tmr_o, 0);
    inv_i = 1'b1; #0.5;
    check(tmr_o === 1'b1, "R4 reset output inverted", tmr_o, 1);
    inv_i = 1'b0;
  endtask

  task automatic t_no_arm();
    int n;
    power_on(1'b0);
    sel_i = 2'b10; oneshot_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i) rst_ni = 1'b1;
    wait_level(1'b1, 300, n);
    check(n == 301, "R8 idle without master reset", n, 301);
    pulse_mrst();
    wait_level(1'b1, 200, n);
    check(n == 129, "R8 counts after master reset", n, 129);
  endtask

  task automatic t_sel(input logic [1:0] s, input int exp, input string tag);
    int n;
    sel_i = s; oneshot_i = 1'b1; tick_i = 1'b1; inv_i = 1'b0;
    pulse_mrst();
    wait_level(1'b1, exp + 10, n);
    check(n == exp, tag, n, exp);
  endtask

  task automatic t_hold();
    int n;
    t_sel(2'b10, 129, "R5 stage 8 latch");
    wait_level(1'b0, 400, n);
    check(n == 401, "R6 stays high while latched", n, 401);
    @(negedge clk_i) oneshot_i = 1'b0; #0.5;
    check(tmr_o === 1'b1, "R6 mode release keeps bit", tmr_o, 1);
    wait_level(1'b0, 200, n);
    check(n == 128, "R6 counting resumes after release", n, 128);
    @(negedge clk_i) oneshot_i = 1'b1;
    wait_level(1'b1, 200, n);
    check(n == 128, "R5 relatch from mid count", n, 128);
    @(negedge clk_i) mrst_i = 1'b1;
    @(posedge clk_i); #1;
    check(tmr_o === 1'b0, "R6 master reset drops latch", tmr_o, 0);
    @(negedge clk_i) mrst_i = 1'b0;
  endtask

  task automatic t_cont();
    int n;
    sel_i = 2'b01; oneshot_i = 1'b0; tick_i = 1'b1; inv_i = 1'b0;
    pulse_mrst();
    wait_level(1'b1, 600, n);
    check(n == 513, "R3 R1 first rise stage 10", n, 513);
    wait_level(1'b0, 600, n);
    check(n == 512, "R3 fall half period", n, 512);
    wait_level(1'b1, 600, n);
    check(n == 512, "R3 rise half period", n, 512);
  endtask

  task automatic t_inv();
    int n;
    sel_i = 2'b10; oneshot_i = 1'b1; tick_i = 1'b1; inv_i = 1'b1;
    pulse_mrst();
    #0.5;
    check(tmr_o === 1'b1, "R4 inverted idle level", tmr_o, 1);
    wait_level(1'b0, 200, n);
    check(n == 129, "R4 inverted latch", n, 129);
    inv_i = 1'b0;
  endtask

  task automatic t_tick_gate();
    int n;
    sel_i = 2'b10; oneshot_i = 1'b1; tick_i = 1'b0; inv_i = 1'b0;
    pulse_mrst();
    wait_level(1'b1, 50, n);
    check(n == 51, "R10 no advance without tick", n, 51);
    @(negedge clk_i) tick_i = 1'b1;
    wait_level(1'b1, 200, n);
    check(n == 128, "R10 R1 count from tick start", n, 128);
  endtask

  task automatic t_mrst_hold();
    int n;
    sel_i = 2'b10; oneshot_i = 1'b0; tick_i = 1'b1; inv_i = 1'b0;
    @(negedge clk_i) mrst_i = 1'b1;
    wait_level(1'b1, 300, n);
    check(n == 301, "R9 held at zero", n, 301);
    @(negedge clk_i) mrst_i = 1'b0;
    wait_level(1'b1, 200, n);
    check(n == 129, "R9 count from zero after hold", n, 129);
  endtask

  task automatic t_auto();
    int n;
    power_on(1'b1);
    sel_i = 2'b10; oneshot_i = 1'b1; tick_i = 1'b1; inv_i = 1'b0; mrst_i = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    wait_level(1'b1, 200, n);
    check(n == 129, "R7 auto arm after power-on", n, 129);
  endtask

  initial begin
    t_reset_state();
    t_no_arm();
    t_sel(2'b10, 129, "R2 R5 sel 10 stage 8");
    t_sel(2'b01, 513, "R2 R5 sel 01 stage 10");
    t_sel(2'b00, 4097, "R2 R5 sel 00 stage 13");
    t_sel(2'b11, 32769, "R2 R5 sel 11 stage 16");
    t_hold();
    t_cont();
    t_inv();
    t_tick_gate();
    t_mrst_hold();
    t_auto();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule